// File: doc/BRIEF.md
# Four-Lane Serial Word Broadcaster

The block sends a 17-bit frequency-increment word from one master to many receiving modules over four shared single-bit lines. It is built for fixed, short latency. The transmitter spreads each word across the four lanes, so the lanes carry it in parallel, one slot per bit period. A frame is a start bit that is high on every lane, then five data slots, then an idle low period. A divider sets the bit period and drives a bit-clock enable. A rate select makes the bit period twice as long, which lets receivers cope with more skew between modules.

Each receiver watches the lanes with its own clock. When it sees a start bit it counts half a bit period to reach the middle of that bit. It then samples each data slot at its middle and rebuilds the word. After the last slot it gives a one-cycle valid strobe. The receiver also checks that all four start bits were seen in the same bit period. If they were not, it flags a sync error and drops that frame. The top module holds one transmitter and one receiver. The receiver has its own lane input, so a chain of modules, or a bench, can feed it skewed copies of the lines.

Top module: `lane_bcast`

## Requirements
- R1: While reset is high, `lanes_out` is 0, `bit_en` is 0, `rx_valid` is 0, `rx_word` is 0 and `rx_sync_err` is 0.
- R2: `bit_en` is high for one cycle every P clocks. P = DIV when `rate_sel` is 0, and P = 2·DIV when `rate_sel` is 1 (DIV = 2 by default).
- R3: `lanes_out` changes only on the clock edge that follows a `bit_en` cycle. A frame is one bit period with all four lanes at 1, then five data slots, then lanes at 0. In data slot s (0..4), lane k carries word bit 4·s+k, and that lane is 0 where 4·s+k ≥ 17. The lanes stay 0 for at least one bit period between frames.
- R4: `load` stores `word_in` only when no frame is pending or in progress. A `load` during a frame has no effect: no second frame follows.
- R5: For each frame whose start bits line up, the receiver raises `rx_valid` for exactly one cycle, and `rx_word` then equals the word that was sent.
- R6: `rx_valid` rises exactly 1 + P/2 + 5·P clock cycles after the first cycle in which any lane of `lanes_in` is seen high.
- R7: At the middle of the start bit the receiver checks all four lanes. If any lane is 0, `rx_sync_err` is set and the frame produces no `rx_valid`. The next frame whose start bits line up clears the flag.
- R8: A single lane lagging the others by up to P/2 clocks is received correctly. A lag of P/2+1 clocks raises the sync error. So a lag of 2 clocks fails at P = 2 and passes at P = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0: bit period DIV clocks; 1: bit period 2·DIV clocks (change only while idle) |
| load | input | 1 | Strobe that stores `word_in` for broadcast |
| word_in | input | 17 | Frequency-increment word to send |
| lanes_out | output | 4 | Transmitted lane levels |
| bit_en | output | 1 | Bit-clock enable, one cycle per bit period |
| lanes_in | input | 4 | Lane levels seen by the receiver |
| rx_word | output | 17 | Rebuilt word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| rx_sync_err | output | 1 | Start bits were not aligned on the last frame |

## Verification
The first lane change in a frame comes one clock after a `bit_en` cycle. The bench counts cycles from the negative edge at which the start bit first shows on `lanes_out`, and every later result is checked at a fixed offset from that point. A lane slot is due at the negative edge after each `bit_en` cycle. The valid strobe and the word are due exactly 1 + P/2 + 5·P cycles later, and the bench checks that no strobe appears at any other cycle. The sync flag is read once the frame window has closed, after any skewed lane has settled.

// File: rtl/lane_bcast_pkg.sv
package lane_bcast_pkg;

    localparam int WORD_W  = 17;
    localparam int LANES   = 4;
    localparam int SLOTS   = (WORD_W + LANES - 1) / LANES;
    localparam int FRAME_W = SLOTS * LANES;
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [LANES-1:0]   lanes_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [SLOT_W-1:0]  slot_t;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_GAP} tx_state_e;
    typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_DRAIN} rx_state_e;

    // Lane k of slot s carries word bit s*LANES+k; positions past the word are zero.
    function automatic lanes_t slot_bits(word_t w, slot_t s);
        frame_t ext;
        ext = FRAME_W'(w);
        return lanes_t'(ext >> (s * LANES));
    endfunction

endpackage

// File: rtl/lbc_bitclk.sv
module lbc_bitclk #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    output logic bit_en
);
    localparam int CW = $clog2(2 * DIV);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;

    assign last_c = rate_sel ? CW'(2 * DIV - 1) : CW'(DIV - 1);
    assign bit_en = (cnt_q == last_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q >= last_c) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> !bit_en);

endmodule

// File: rtl/lbc_tx.sv
module lbc_tx
    import lane_bcast_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  logic   load,
    input  word_t  word_in,
    output lanes_t lanes
);
    tx_state_e state_q;
    word_t     word_q;
    slot_t     slot_q;
    logic      pend_q;
    lanes_t    lanes_q;
    logic      busy;

    assign busy  = pend_q || (state_q != TX_IDLE);
    assign lanes = lanes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            word_q  <= '0;
            slot_q  <= '0;
            pend_q  <= 1'b0;
            lanes_q <= '0;
        end else begin
            if (load && !busy) begin
                word_q <= word_in;
                pend_q <= 1'b1;
            end
            if (bit_en) begin
                case (state_q)
                    TX_IDLE: begin
                        if (pend_q) begin
                            pend_q  <= 1'b0;
                            state_q <= TX_START;
                            lanes_q <= '1;
                        end
                    end
                    TX_START: begin
                        state_q <= TX_DATA;
                        slot_q  <= '0;
                        lanes_q <= slot_bits(word_q, '0);
                    end
                    TX_DATA: begin
                        if (slot_q == SLOT_W'(SLOTS - 1)) begin
                            state_q <= TX_GAP;
                            lanes_q <= '0;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            lanes_q <= slot_bits(word_q, slot_q + 1'b1);
                        end
                    end
                    default: begin
                        state_q <= TX_IDLE;
                        lanes_q <= '0;
                    end
                endcase
            end
        end
    end

    a_r3_lanes_on_bit_en: assert property (@(posedge clk) disable iff (rst)
        (lanes_q != $past(lanes_q)) |-> $past(bit_en));

    a_r4_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
        (load && busy) |=> $stable(word_q));

endmodule

// File: rtl/lbc_rx.sv
module lbc_rx
    import lane_bcast_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   rate_sel,
    input  lanes_t lanes_in,
    output word_t  rx_word,
    output logic   rx_valid,
    output logic   rx_sync_err
);
    localparam int CW = $clog2(2 * DIV);

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    slot_t         slot_q;
    frame_t        acc_q;
    frame_t        nxt;
    logic          bad_q;
    logic [CW-1:0] last_c;
    logic [CW-1:0] half_c;

    assign last_c = rate_sel ? CW'(2 * DIV - 1) : CW'(DIV - 1);
    assign half_c = rate_sel ? CW'(DIV - 1)     : CW'(DIV / 2 - 1);
    assign nxt    = {lanes_in, acc_q[FRAME_W-1:LANES]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= RX_HUNT;
            cnt_q       <= '0;
            slot_q      <= '0;
            acc_q       <= '0;
            bad_q       <= 1'b0;
            rx_word     <= '0;
            rx_valid    <= 1'b0;
            rx_sync_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (state_q)
                RX_HUNT: begin
                    if (|lanes_in) begin
                        state_q <= RX_START;
                        cnt_q   <= half_c;
                    end
                end
                RX_START: begin
                    if (cnt_q == '0) begin
                        bad_q       <= (lanes_in != '1);
                        rx_sync_err <= (lanes_in != '1);
                        state_q     <= RX_DATA;
                        slot_q      <= '0;
                        cnt_q       <= last_c;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == '0) begin
                        acc_q <= nxt;
                        cnt_q <= last_c;
                        if (slot_q == SLOT_W'(SLOTS - 1)) begin
                            state_q <= RX_DRAIN;
                            if (!bad_q) begin
                                rx_word  <= nxt[WORD_W-1:0];
                                rx_valid <= 1'b1;
                            end
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (lanes_in == '0) begin
                        state_q <= RX_HUNT;
                    end
                end
            endcase
        end
    end

    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r7_valid_clean: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !rx_sync_err);

endmodule

// File: rtl/lane_bcast.sv
module lane_bcast
    import lane_bcast_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rate_sel,
    input  logic        load,
    input  logic [16:0] word_in,
    output logic [3:0]  lanes_out,
    output logic        bit_en,
    input  logic [3:0]  lanes_in,
    output logic [16:0] rx_word,
    output logic        rx_valid,
    output logic        rx_sync_err
);
    lbc_bitclk #(.DIV(DIV)) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .bit_en   (bit_en)
    );

    lbc_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .load    (load),
        .word_in (word_in),
        .lanes   (lanes_out)
    );

    lbc_rx #(.DIV(DIV)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .rate_sel    (rate_sel),
        .lanes_in    (lanes_in),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid),
        .rx_sync_err (rx_sync_err)
    );

endmodule

// File: tb/lane_bcast_test.sv
`timescale 1ns/1ps
module lane_bcast_test;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_sel = 1'b0;
    logic        load = 1'b0;
    logic [16:0] word_in = '0;
    logic [3:0]  lanes_out;
    logic        bit_en;
    logic [3:0]  lanes_in;
    logic [16:0] rx_word;
    logic        rx_valid;
    logic        rx_sync_err;

    int checks = 0;
    int failures = 0;
    int skew3 = 0;
    bit done = 0;
    logic [2:0] dl = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) dl <= {dl[1:0], lanes_out[3]};
    assign lanes_in = {(skew3 == 0) ? lanes_out[3] : dl[skew3-1], lanes_out[2:0]};

    lane_bcast #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .load(load), .word_in(word_in),
        .lanes_out(lanes_out), .bit_en(bit_en), .lanes_in(lanes_in),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_sync_err(rx_sync_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int period();
        return rate_sel ? 2 * DIV : DIV;
    endfunction

    function automatic logic [3:0] exp_slot(logic [16:0] w, int s);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            int idx = 4 * s + k;
            r[k] = (idx < 17) ? w[idx] : 1'b0;
        end
        return r;
    endfunction

    task automatic check_period();
        int n = 0;
        @(negedge clk);
        while (!bit_en) @(negedge clk);
        @(negedge clk); n = 1;
        while (!bit_en) begin @(negedge clk); n++; end
        chk(n == period(), "R2", "bit_en spacing", n, period());
    endtask

    task automatic run_frame(input logic [16:0] w, input bit expect_ok, input bit inject);
        int p = period();
        int lat = 1 + p / 2 + 5 * p;
        int idx = 0;
        int vcount = 0;
        bit prev_en;
        logic [3:0] e;
        @(negedge clk); word_in = w; load = 1'b1;
        @(negedge clk); load = 1'b0;
        while (lanes_out == 4'h0) @(negedge clk);
        chk(lanes_out == 4'hF, "R3", "start bit", lanes_out, 4'hF);
        prev_en = bit_en;
        for (int c = 1; c <= lat + 3; c++) begin
            @(negedge clk);
            if (inject && c == 3) begin word_in = ~w; load = 1'b1; end
            if (inject && c == 4) load = 1'b0;
            if (prev_en) begin
                idx++;
                e = (idx <= 5) ? exp_slot(w, idx - 1) : 4'h0;
                chk(lanes_out == e, "R3", "lane slot", lanes_out, e);
            end
            prev_en = bit_en;
            if (rx_valid) vcount++;
            if (expect_ok && c == lat) begin
                chk(rx_valid == 1'b1, "R6", "valid at fixed latency", rx_valid, 1);
                chk(rx_word == w, "R5", "rebuilt word", rx_word, w);
            end
        end
        chk(vcount == (expect_ok ? 1 : 0), expect_ok ? "R5" : "R7", "valid pulse count", vcount, expect_ok ? 1 : 0);
        chk(rx_sync_err == !expect_ok, "R7", "sync flag after frame", rx_sync_err, !expect_ok);
        repeat (2 * p + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R5 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [16:0] lf = 17'h1ACE5;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(lanes_out == 4'h0, "R1", "lanes in reset", lanes_out, 0);
        chk(bit_en == 1'b0, "R1", "bit_en in reset", bit_en, 0);
        chk(rx_valid == 1'b0, "R1", "valid in reset", rx_valid, 0);
        chk(rx_word == 17'h0, "R1", "word in reset", rx_word, 0);
        chk(rx_sync_err == 1'b0, "R1", "sync flag in reset", rx_sync_err, 0);
        rst = 1'b0;
        for (int r = 0; r < 2; r++) begin
            rate_sel = r[0];
            check_period();
            check_period();
            run_frame(17'h00000, 1, 0);
            run_frame(17'h1FFFF, 1, 0);
            for (int b = 0; b < 17; b++) run_frame(17'h1 << b, 1, 0);
            for (int b = 0; b < 17; b++) run_frame(~(17'h1 << b), 1, 0);
            for (int i = 0; i < 20; i++) begin
                lf = {lf[15:0], lf[16] ^ lf[13]};
                run_frame(lf, 1, 0);
            end
        end
        // R4: load during a frame is ignored
        rate_sel = 1'b0;
        run_frame(17'h0A5C3, 1, 1);
        begin
            int stray = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (lanes_out != 4'h0 || rx_valid) stray++;
            end
            chk(stray == 0, "R4", "no frame after ignored load", stray, 0);
        end
        // R8: skew tolerance, R7: misaligned start bits
        skew3 = 1; run_frame(17'h1B38D, 1, 0);
        skew3 = 2; run_frame(17'h0F0F0, 0, 0);
        rate_sel = 1'b1;
        skew3 = 2; run_frame(17'h0F0F0, 1, 0);
        skew3 = 3; run_frame(17'h12345, 0, 0);
        rate_sel = 1'b0;
        skew3 = 0; run_frame(17'h1D00F, 1, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule